// File: doc/BRIEF.md
# Factory Bad-Block Scanner

This engine runs once, straight out of reset, and sorts every erase block of an attached NAND array into usable or factory-rejected. The NAND parts come from the factory with their rejected blocks marked by a non-erased byte at fixed positions. The engine visits the blocks in ascending order. It does not pull whole pages. For each of the first two pages of a block it asks a page-read sequencer for one byte at column 0. It then asks for one byte at the spare-area column 2048 as a column change within the page that is already open.

A block is rejected when any one of its four sampled bytes differs from the erased value 8'hFF. The verdict for each block goes into a bitmap that holds one bit per block. A combinational index port reads the bitmap, and a running counter gives the total of rejected blocks. When the last block has been classified, a done flag rises. If the sequencer reports a timeout while the engine waits for a byte, the scan halts. An error flag then rises, together with the index of the block that was in progress.

The sequencer link carries one outstanding request at a time. The engine holds a request until the sequencer accepts it. It then waits for either a data strobe or a timeout pulse.

Top module: `nand_badblk_scanner`

## Requirements
- R1: While reset is asserted and directly after it, scan_done, scan_err and bad_count read 0, and every bitmap bit reads 0. The scan starts without any further input once reset is released.
- R2: For block b, exactly four requests go out, in this order. Step 0 has row b*64+0, column 0 and req_colchg=0. Step 1 has row b*64+0, column 2048 and req_colchg=1. Step 2 has row b*64+1, column 0 and req_colchg=0. Step 3 has row b*64+1, column 2048 and req_colchg=1. The row carries the block in bits 15:6 and the page in bits 5:0.
- R3: Blocks are visited from index 0 up to the last index. Only one request is outstanding at a time, so req_valid stays low after an accepted request until the byte or a timeout comes back.
- R4: A block's bitmap bit reads 1 if any of its four sampled bytes is not 8'hFF. It reads 0 if all four bytes equal 8'hFF.
- R5: bad_count equals the number of blocks recorded as bad. It changes only when a block is recorded, and it reaches 1024 when every block is bad.
- R6: After the byte for step 3 of the last block, scan_done goes high and stays high, scan_busy goes low, and no further request is raised.
- R7: A timeout pulse while a byte is awaited stops the scan. scan_err goes high and holds, err_block holds the index of the block in progress, and no further request is raised. The block in progress is not recorded, so its bitmap bit and bad_count are left unchanged.
- R8: When a timeout and a data strobe arrive in the same cycle, the timeout wins and the byte is discarded.
- R9: While req_valid is high and req_ready is low, req_valid, req_row, req_col and req_colchg hold their values.
- R10: scan_done and scan_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Sequencer accepts the pending request |
| req_row | output | 16 | Row address: block in bits 15:6, page in bits 5:0 |
| req_col | output | 12 | Column to sample |
| req_colchg | output | 1 | 1 = column change in the open page, 0 = open a new page |
| rd_valid | input | 1 | Sampled byte strobe |
| rd_data | input | 8 | Sampled byte |
| rd_timeout | input | 1 | Sequencer timeout pulse |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | All blocks classified |
| scan_err | output | 1 | Scan stopped on a timeout |
| err_block | output | 10 | Block in progress when the scan stopped (valid with scan_err) |
| map_idx | input | 10 | Bitmap read index |
| map_bad | output | 1 | Bitmap bit at map_idx, 1 = bad |
| bad_count | output | 11 | Number of blocks recorded as bad |

## Verification
A data strobe and a timeout pulse can reach the engine in the same cycle. A block's verdict is committed on that same strobe when it carries the block's fourth byte. The bench provokes this collision on the final byte of a block whose other three bytes are erased, and it drives that final byte as 8'h00. It then judges the outcome at the ports. The error flag must be set with that block's index. The block's bitmap bit must still read 0, and bad_count must equal the number of bad blocks before it. This shows the timeout won and the bad byte never reached the bitmap. Separately, full randomised scans check every request's row, column and kind, and then sweep the whole bitmap.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERR   = 2'd3
  } scan_st_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nbs_walk_ctrl.sv
module nbs_walk_ctrl
  import nbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int PAGE_BITS  = 6,
  parameter int COL_W      = 12,
  parameter int SPARE_COL  = 2048,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int ROW_W     = BLK_W + PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [ROW_W-1:0] req_row,
  output logic [COL_W-1:0] req_col,
  output logic             req_colchg,
  input  logic             rd_valid,
  input  logic             rd_timeout,
  output logic             byte_stb,
  output logic             blk_last_stb,
  output logic [BLK_W-1:0] blk_idx,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_t         st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [1:0]       step_q, step_d;

  // next-state process
  always_comb begin
    st_d   = st_q;
    blk_d  = blk_q;
    step_d = step_q;
    unique case (st_q)
      ST_ISSUE: begin
        if (req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_timeout) begin
          st_d = ST_ERR;
        end else if (rd_valid) begin
          step_d = step_q + 2'd1;
          if (step_q == 2'd3) begin
            if (blk_q == LAST_BLK) begin
              st_d = ST_DONE;
            end else begin
              blk_d = blk_q + BLK_W'(1);
              st_d  = ST_ISSUE;
            end
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      default: st_d = st_q;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ISSUE;
      blk_q  <= '0;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      step_q <= step_d;
    end
  end

  assign req_valid    = (st_q == ST_ISSUE);
  assign req_row      = {blk_q, PAGE_BITS'(step_q[1])};
  assign req_col      = step_q[0] ? COL_W'(SPARE_COL) : '0;
  assign req_colchg   = step_q[0];
  assign byte_stb     = (st_q == ST_WAIT) && rd_valid && !rd_timeout;
  assign blk_last_stb = byte_stb && (step_q == 2'd3);
  assign blk_idx      = blk_q;
  assign busy         = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
  assign done         = (st_q == ST_DONE);
  assign err          = (st_q == ST_ERR);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)
                                   && $stable(req_col) && $stable(req_colchg)));

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !req_valid && !busy));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !req_valid && $stable(blk_idx)));

endmodule

// File: rtl/nbs_marker_eval.sv
module nbs_marker_eval
  import nbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  input  logic       last_stb,
  output logic       wr_en,
  output logic       wr_bad
);

  logic acc_q, acc_d, acc_en;
  logic mismatch;

  assign mismatch = (byte_val != ERASED_BYTE);

  // next-state process
  always_comb begin
    acc_en = byte_stb;
    acc_d  = last_stb ? 1'b0 : (acc_q | mismatch);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign wr_en  = last_stb;
  assign wr_bad = acc_q | mismatch;

  // R4
  stb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_stb |-> byte_stb);

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_stb |=> !acc_q);

endmodule

// File: rtl/nbs_badmap_store.sv
module nbs_badmap_store #(
  parameter int NUM_BLOCKS = 1024,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic             wr_bad,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bad,
  output logic [CNT_W-1:0] bad_count
);

  logic [NUM_BLOCKS-1:0] map_q, map_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  cnt_en;

  // next-state process
  always_comb begin
    map_d  = map_q;
    if (wr_en) map_d[wr_idx] = wr_bad;
    cnt_en = wr_en && wr_bad;
    cnt_d  = cnt_q + CNT_W'(1);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en)  map_q <= map_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rd_bad    = map_q[rd_idx];
  assign bad_count = cnt_q;

  // R5
  count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bad_count));

  // R5
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_count <= CNT_W'(NUM_BLOCKS));

endmodule

// File: rtl/nand_badblk_scanner.sv
module nand_badblk_scanner #(
  parameter int NUM_BLOCKS = 1024,
  parameter int PAGE_BITS  = 6,
  parameter int COL_W      = 12,
  parameter int SPARE_COL  = 2048,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int ROW_W     = BLK_W + PAGE_BITS,
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [ROW_W-1:0] req_row,
  output logic [COL_W-1:0] req_col,
  output logic             req_colchg,
  input  logic             rd_valid,
  input  logic [7:0]       rd_data,
  input  logic             rd_timeout,
  output logic             scan_busy,
  output logic             scan_done,
  output logic             scan_err,
  output logic [BLK_W-1:0] err_block,
  input  logic [BLK_W-1:0] map_idx,
  output logic             map_bad,
  output logic [CNT_W-1:0] bad_count
);

  logic             byte_stb, blk_last_stb;
  logic [BLK_W-1:0] blk_idx;
  logic             wr_en, wr_bad;

  nbs_walk_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .PAGE_BITS (PAGE_BITS),
    .COL_W     (COL_W),
    .SPARE_COL (SPARE_COL)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_colchg  (req_colchg),
    .rd_valid    (rd_valid),
    .rd_timeout  (rd_timeout),
    .byte_stb    (byte_stb),
    .blk_last_stb(blk_last_stb),
    .blk_idx     (blk_idx),
    .busy        (scan_busy),
    .done        (scan_done),
    .err         (scan_err)
  );

  nbs_marker_eval u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_stb(byte_stb),
    .byte_val(rd_data),
    .last_stb(blk_last_stb),
    .wr_en   (wr_en),
    .wr_bad  (wr_bad)
  );

  nbs_badmap_store #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (blk_idx),
    .wr_bad   (wr_bad),
    .rd_idx   (map_idx),
    .rd_bad   (map_bad),
    .bad_count(bad_count)
  );

  assign err_block = blk_idx;

  // R8
  timeout_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_timeout |-> !wr_en);

endmodule

// File: tb/tb_nand_badblk_scanner.sv
module tb_nand_badblk_scanner;

  localparam int NB = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [15:0] req_row;
  logic [11:0] req_col;
  logic        req_colchg;
  logic        rd_valid, rd_timeout;
  logic [7:0]  rd_data;
  logic        scan_busy, scan_done, scan_err;
  logic [9:0]  err_block, map_idx;
  logic        map_bad;
  logic [10:0] bad_count;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mk [0:NB-1][0:3];
  bit         exp_bad [0:NB-1];

  always #10 clk = ~clk;

  nand_badblk_scanner dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_colchg(req_colchg),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_timeout(rd_timeout),
    .scan_busy(scan_busy), .scan_done(scan_done), .scan_err(scan_err),
    .err_block(err_block), .map_idx(map_idx), .map_bad(map_bad),
    .bad_count(bad_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_row(input int b, input int s);
    return b * 64 + (s >> 1);
  endfunction

  function automatic int exp_col(input int s);
    return (s % 2 == 1) ? 2048 : 0;
  endfunction

  function automatic int count_bad(input int upto);
    int c = 0;
    for (int i = 0; i < upto; i++) if (exp_bad[i]) c++;
    return c;
  endfunction

  function automatic void recompute();
    for (int b = 0; b < NB; b++) begin
      exp_bad[b] = 1'b0;
      for (int s = 0; s < 4; s++) if (mk[b][s] != 8'hFF) exp_bad[b] = 1'b1;
    end
  endfunction

  // mode 0 random, 1 all erased, 2 all marked
  function automatic void fill(input int mode);
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 4; s++)
        mk[b][s] = (mode == 2) ? 8'h00 : 8'hFF;
    if (mode == 0) begin
      for (int b = 0; b < NB; b++) begin
        if ($urandom % 8 == 0) mk[b][$urandom % 4] = 8'($urandom % 255);
        if ($urandom % 64 == 0) mk[b][$urandom % 4] = 8'($urandom % 255);
      end
      mk[0][3]    = 8'hFE;
      mk[NB-1][0] = 8'h7F;
      mk[1]       = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    end
    recompute();
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_ready = 1'b0; rd_valid = 1'b0; rd_timeout = 1'b0;
    rd_data = 8'h00; map_idx = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!scan_done, "R1 done in reset", int'(scan_done), 0);
    chk(!scan_err, "R1 err in reset", int'(scan_err), 0);
    chk(bad_count == 0, "R1 count in reset", int'(bad_count), 0);
    for (int i = 0; i < NB; i += 97) begin
      map_idx = 10'(i); #1;
      chk(!map_bad, "R1 map in reset", int'(map_bad), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(scan_busy && req_valid, "R1 scan starts", int'(req_valid), 1);
  endtask

  task automatic chk_req(input int b, input int s, input string tag);
    chk(req_valid, tag, int'(req_valid), 1);
    chk(int'(req_row) == exp_row(b, s), tag, int'(req_row), exp_row(b, s));
    chk(int'(req_col) == exp_col(s), tag, int'(req_col), exp_col(s));
    chk(int'(req_colchg) == (s % 2), tag, int'(req_colchg), s % 2);
  endtask

  task automatic run_scan(input int to_blk);
    int b = 0;
    int s = 0;
    int d;
    forever begin
      if (scan_done || scan_err) break;
      if (!req_valid) begin @(negedge clk); continue; end
      chk_req(b, s, "R2 request fields");
      d = $urandom % 3;
      repeat (d) begin @(negedge clk); chk_req(b, s, "R9 held request"); end
      req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
      chk(!req_valid, "R3 single outstanding", int'(req_valid), 0);
      d = $urandom % 3;
      repeat (d) @(negedge clk);
      rd_valid = 1'b1; rd_data = mk[b][s];
      if (b == to_blk && s == 3) begin rd_timeout = 1'b1; rd_data = 8'h00; end
      @(negedge clk);
      rd_valid = 1'b0; rd_timeout = 1'b0;
      if (b == to_blk && s == 3) break;
      s++;
      if (s == 4) begin s = 0; b++; end
    end
  endtask

  task automatic sweep_map(input int limit, input string tag);
    for (int i = 0; i < NB; i++) begin
      map_idx = 10'(i); #1;
      if (i < limit) chk(map_bad == exp_bad[i], tag, int'(map_bad), int'(exp_bad[i]));
      else chk(!map_bad, tag, int'(map_bad), 0);
    end
  endtask

  task automatic full_run(input int mode, input string name);
    fill(mode);
    do_reset();
    run_scan(-1);
    // R6
    chk(scan_done, {"R6 done ", name}, int'(scan_done), 1);
    chk(!scan_busy, {"R6 busy ", name}, int'(scan_busy), 0);
    // R10
    chk(!scan_err, {"R10 no err ", name}, int'(scan_err), 0);
    // R5
    chk(int'(bad_count) == count_bad(NB), {"R5 count ", name}, int'(bad_count), count_bad(NB));
    repeat (5) begin
      @(negedge clk);
      chk(!req_valid, {"R6 quiet ", name}, int'(req_valid), 0);
    end
    // R4
    sweep_map(NB, {"R4 map ", name});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    full_run(0, "random");
    full_run(1, "all erased");
    full_run(2, "all marked");

    // R7 R8: timeout together with a bad final byte on block 5
    fill(0);
    mk[5] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    recompute();
    do_reset();
    run_scan(5);
    chk(scan_err, "R7 err raised", int'(scan_err), 1);
    chk(int'(err_block) == 5, "R7 err block", int'(err_block), 5);
    chk(!scan_done, "R10 no done on err", int'(scan_done), 0);
    chk(!scan_busy, "R7 busy low", int'(scan_busy), 0);
    chk(int'(bad_count) == count_bad(5), "R8 count excludes block", int'(bad_count), count_bad(5));
    repeat (6) begin
      @(negedge clk);
      chk(!req_valid && scan_err && err_block == 10'd5, "R7 stopped", int'(req_valid), 0);
    end
    map_idx = 10'd5; #1;
    chk(!map_bad, "R8 discarded byte", int'(map_bad), 0);
    sweep_map(5, "R7 map prefix");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule